// File: doc/BRIEF.md
# Class-D Output Stage Protection Supervisor

This block watches the protection conditions of a stereo class-D power stage and decides, every clock, whether the output bridge may switch and whether a fault must be reported to the host. Analog comparators supply the overcurrent, overtemperature, undervoltage and overvoltage conditions as digital flags. The block judges DC offset itself by timing the differential duty cycle of each channel's PWM pair over each switching period.

Faults fall into two classes. Overcurrent, overtemperature and DC offset are held in latches. A held fault pulls the active-low fault line down and keeps the bridge in high impedance until the shutdown input is taken low. Supply undervoltage and overvoltage only float the bridge while they last, and they do not touch the fault line. They also restart the start-up delay, and the delay must run out before the bridge is enabled. When the delay ends, the gain/mode strap inputs are captured and held.

Top module: `amp_prot_sup`

## Requirements
- R1: While reset is applied and just after it, `fault_n` is 1, `out_hiz` is 1, `startup_done` is 0 and `cfg_q` is 0.
- R2: `startup_done` rises after exactly STARTUP_CYC consecutive clock edges that see `sd_n` high with both `uv_flag` and `ov_flag` low. Any edge that sees `sd_n` low or either supply flag high returns the timer to zero, so `startup_done` is 0 after that edge.
- R3: `cfg_q` takes the value of `cfg_strap` on the edge where `startup_done` rises, and it keeps that value at every other edge.
- R4: `out_hiz` is 1 whenever `sd_n` is 0, `mute` is 1, a latched fault is held, `uv_flag` or `ov_flag` is 1, or `startup_done` is 0. Otherwise it is 0.
- R5: `oc_flag` or `ot_flag` sampled high on an edge with `sd_n` high sets a latch. `fault_n` is 0 from that edge on, and it stays 0 while `sd_n` stays high, even after the flag drops.
- R6: An edge that sees `sd_n` low clears every latch, so `fault_n` is 1 after it. If a fault flag and `sd_n` low arrive on the same edge, the latch stays clear.
- R7: `uv_flag` and `ov_flag` never drive `fault_n` low. The bridge floats only while they are high, plus the start-up delay they restart.
- R8: A switching period is the run of cycles up to and including the cycle with `period_stb` high. A cycle counts as positive when `pwm_p` is 1 and `pwm_n` is 0, and as negative in the opposite case. A period is imbalanced at a polarity when that polarity's count times 5 exceeds the period length times 3, which means strictly above 60%.
- R9: When either channel has more than DC_PERIODS consecutive periods imbalanced at the same polarity, a DC latch is set. `fault_n` goes to 0 one edge after the strobe edge that completes period DC_PERIODS+1.
- R10: The consecutive-period count of a channel restarts when a period is not imbalanced or when its polarity differs from the previous period's.
- R11: The DC latch is cleared by `sd_n` low in the same way as the other latched faults. An edge with `sd_n` low also discards any partial DC measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_n | input | 1 | Shutdown control, low = shut down and clear latches |
| mute | input | 1 | High forces the bridge to high impedance |
| oc_flag | input | 1 | Overcurrent comparator flag |
| ot_flag | input | 1 | Overtemperature comparator flag |
| uv_flag | input | 1 | Supply undervoltage flag |
| ov_flag | input | 1 | Supply overvoltage flag |
| period_stb | input | 1 | High on the last cycle of each switching period |
| pwm_p | input | NUM_CH | Positive-side PWM of each channel |
| pwm_n | input | NUM_CH | Negative-side PWM of each channel |
| cfg_strap | input | STRAP_W | Gain/mode strap value to capture |
| fault_n | output | 1 | Active-low latched-fault report |
| out_hiz | output | 1 | High = bridge outputs in high impedance |
| startup_done | output | 1 | Start-up delay has elapsed |
| cfg_q | output | STRAP_W | Strap value captured at the end of start-up |

## Verification
The assertions check the per-cycle rules on every cycle: shutdown clears the fault report, a held fault persists while shutdown stays released, a fault flag or DC trip is reported one edge later, supply flags drop the start-up flag, and the strap register changes only on the start-up edge. The exact start-up length, the duty threshold at precisely 60%, the restart of the period count on a polarity flip, and the edge on which a DC trip reaches the fault line appear only in the bench's directed scenarios. A seeded random phase of mute and supply glitches is then compared against the bench's own enable model.

// File: rtl/amp_prot_pkg.sv
package amp_prot_pkg;

  typedef enum logic [1:0] {
    POL_NONE = 2'd0,
    POL_POS  = 2'd1,
    POL_NEG  = 2'd2
  } pol_e;

  // strictly above 60 percent: act/len > 3/5
  function automatic logic duty_over(input logic [31:0] act, input logic [31:0] len);
    return (act * 32'd5) > (len * 32'd3);
  endfunction

  function automatic pol_e classify(input logic [31:0] pos, input logic [31:0] neg,
                                    input logic [31:0] len);
    if (duty_over(pos, len)) return POL_POS;
    if (duty_over(neg, len)) return POL_NEG;
    return POL_NONE;
  endfunction

endpackage

// File: rtl/amp_dc_chan.sv
module amp_dc_chan
  import amp_prot_pkg::*;
#(
  parameter int PER_W      = 12,
  parameter int DC_PERIODS = 168000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic stb,
  input  logic pwm_p,
  input  logic pwm_n,
  output logic dc_over
);
  localparam int RUN_W = $clog2(DC_PERIODS + 2);
  localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(DC_PERIODS);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(DC_PERIODS + 1);
  localparam logic [PER_W-1:0] CNT_MAX = '1;

  logic [PER_W-1:0] pos_q, neg_q, len_q;
  logic [PER_W:0]   pos_tot, neg_tot, len_tot;
  logic [RUN_W-1:0] run_q, run_nx;
  pol_e             last_q, pol_now;
  logic             pos_hit, neg_hit;

  assign pos_hit = pwm_p & ~pwm_n;
  assign neg_hit = pwm_n & ~pwm_p;

  assign pos_tot = {1'b0, pos_q} + (PER_W+1)'(pos_hit);
  assign neg_tot = {1'b0, neg_q} + (PER_W+1)'(neg_hit);
  assign len_tot = {1'b0, len_q} + (PER_W+1)'(1);

  assign pol_now = classify(32'(pos_tot), 32'(neg_tot), 32'(len_tot));

  always_comb begin
    run_nx = run_q;
    if (pol_now == POL_NONE)   run_nx = '0;
    else if (pol_now != last_q) run_nx = RUN_W'(1);
    else if (run_q != RUN_TOP) run_nx = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      neg_q  <= '0;
      len_q  <= '0;
      run_q  <= '0;
      last_q <= POL_NONE;
    end else if (clr) begin
      pos_q  <= '0;
      neg_q  <= '0;
      len_q  <= '0;
      run_q  <= '0;
      last_q <= POL_NONE;
    end else if (stb) begin
      pos_q  <= '0;
      neg_q  <= '0;
      len_q  <= '0;
      run_q  <= run_nx;
      last_q <= pol_now;
    end else begin
      if (pos_hit && pos_q != CNT_MAX) pos_q <= pos_q + 1'b1;
      if (neg_hit && neg_q != CNT_MAX) neg_q <= neg_q + 1'b1;
      if (len_q != CNT_MAX)            len_q <= len_q + 1'b1;
    end
  end

  assign dc_over = run_q > RUN_LIM;

endmodule

// File: rtl/amp_fault_latch.sv
module amp_fault_latch #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sd_n,
  input  logic [N-1:0] set_vec,
  output logic [N-1:0] lat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lat_q <= '0;
    else if (!sd_n) lat_q <= '0;
    else            lat_q <= lat_q | set_vec;
  end
endmodule

// File: rtl/amp_startup_timer.sv
module amp_startup_timer #(
  parameter int STARTUP_CYC = 500000,
  parameter int STRAP_W     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  input  logic [STRAP_W-1:0] strap,
  output logic               done,
  output logic               end_evt,
  output logic [STRAP_W-1:0] cfg_q
);
  localparam int CNT_W = $clog2(STARTUP_CYC + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(STARTUP_CYC);
  localparam logic [CNT_W-1:0] PRE = CNT_W'(STARTUP_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign end_evt = !hold && (cnt_q == PRE);
  assign done    = (cnt_q == LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (hold)       cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= '0;
    else if (end_evt) cfg_q <= strap;
  end
endmodule

// File: rtl/amp_prot_sup.sv
module amp_prot_sup #(
  parameter int NUM_CH      = 2,
  parameter int STARTUP_CYC = 500000,
  parameter int DC_PERIODS  = 168000,
  parameter int PER_W       = 12,
  parameter int STRAP_W     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sd_n,
  input  logic               mute,
  input  logic               oc_flag,
  input  logic               ot_flag,
  input  logic               uv_flag,
  input  logic               ov_flag,
  input  logic               period_stb,
  input  logic [NUM_CH-1:0]  pwm_p,
  input  logic [NUM_CH-1:0]  pwm_n,
  input  logic [STRAP_W-1:0] cfg_strap,
  output logic               fault_n,
  output logic               out_hiz,
  output logic               startup_done,
  output logic [STRAP_W-1:0] cfg_q
);
  localparam int NLAT = 3;

  logic [NUM_CH-1:0] dc_vec;
  logic [NLAT-1:0]   lat_q;
  logic              dc_any;
  logic              sc_active;
  logic              any_latched;
  logic              startup_end_evt;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    amp_dc_chan #(
      .PER_W(PER_W),
      .DC_PERIODS(DC_PERIODS)
    ) u_dc (
      .clk(clk),
      .rst_n(rst_n),
      .clr(!sd_n),
      .stb(period_stb),
      .pwm_p(pwm_p[ch]),
      .pwm_n(pwm_n[ch]),
      .dc_over(dc_vec[ch])
    );
  end

  assign dc_any    = |dc_vec;
  assign sc_active = uv_flag | ov_flag;

  amp_fault_latch #(.N(NLAT)) u_lat (
    .clk(clk),
    .rst_n(rst_n),
    .sd_n(sd_n),
    .set_vec({dc_any, ot_flag, oc_flag}),
    .lat_q(lat_q)
  );

  assign any_latched = |lat_q;

  amp_startup_timer #(
    .STARTUP_CYC(STARTUP_CYC),
    .STRAP_W(STRAP_W)
  ) u_tmr (
    .clk(clk),
    .rst_n(rst_n),
    .hold(!sd_n || sc_active),
    .strap(cfg_strap),
    .done(startup_done),
    .end_evt(startup_end_evt),
    .cfg_q(cfg_q)
  );

  assign fault_n = !any_latched;
  assign out_hiz = !sd_n || mute || any_latched || sc_active || !startup_done;

endmodule

// File: rtl/amp_prot_chk.sv
module amp_prot_chk #(
  parameter int STRAP_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sd_n,
  input logic               oc_flag,
  input logic               ot_flag,
  input logic               uv_flag,
  input logic               ov_flag,
  input logic               dc_any,
  input logic               startup_end_evt,
  input logic [STRAP_W-1:0] cfg_strap,
  input logic               fault_n,
  input logic               out_hiz,
  input logic               startup_done,
  input logic [STRAP_W-1:0] cfg_q
);
  // R6
  sd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_n |=> fault_n);

  // R5
  latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((oc_flag || ot_flag) && sd_n) |=> !fault_n);

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && sd_n) |=> !fault_n);

  // R7
  sc_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_n) |-> ($past(sd_n) && $past(oc_flag || ot_flag || dc_any)));

  // R2
  sc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_flag || ov_flag || !sd_n) |=> !startup_done);

  // R3
  strap_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    startup_end_evt |=> (startup_done && cfg_q == $past(cfg_strap)));

  // R3
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !startup_end_evt |=> $stable(cfg_q));

  // R9
  dc_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_any && sd_n) |=> !fault_n);

  // R4
  hiz_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> out_hiz);
endmodule

bind amp_prot_sup amp_prot_chk #(.STRAP_W(STRAP_W)) u_chk (.*);

// File: tb/sim_amp_prot_sup.sv
`timescale 1ns/1ps
module sim_amp_prot_sup;
  localparam int NCH = 2;
  localparam int S   = 8;
  localparam int DCP = 4;
  localparam int L   = 10;
  localparam int SW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sd_n = 1'b0, mute = 1'b0;
  logic oc_flag = 1'b0, ot_flag = 1'b0, uv_flag = 1'b0, ov_flag = 1'b0;
  logic period_stb = 1'b0;
  logic [NCH-1:0] pwm_p = '0, pwm_n = '0;
  logic [SW-1:0] cfg_strap = '0;
  logic fault_n, out_hiz, startup_done;
  logic [SW-1:0] cfg_q;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  amp_prot_sup #(
    .NUM_CH(NCH), .STARTUP_CYC(S), .DC_PERIODS(DCP), .PER_W(8), .STRAP_W(SW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .sd_n(sd_n), .mute(mute),
    .oc_flag(oc_flag), .ot_flag(ot_flag), .uv_flag(uv_flag), .ov_flag(ov_flag),
    .period_stb(period_stb), .pwm_p(pwm_p), .pwm_n(pwm_n), .cfg_strap(cfg_strap),
    .fault_n(fault_n), .out_hiz(out_hiz), .startup_done(startup_done), .cfg_q(cfg_q)
  );

  function automatic bit exp_hiz(bit sd, bit mu, bit lat, bit uv, bit ov, bit dn);
    return !sd || mu || lat || uv || ov || !dn;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sd_pulse();
    sd_n = 1'b0;
    @(negedge clk);
    sd_n = 1'b1;
  endtask

  // one switching period on channel ch; h active cycles of the chosen polarity
  task automatic run_period(input int ch, input bit neg, input int h);
    for (int i = 0; i < L; i++) begin
      pwm_p[ch]  = !neg && (i < h);
      pwm_n[ch]  = neg && (i < h);
      period_stb = (i == L - 1);
      @(negedge clk);
    end
    period_stb = 1'b0;
    pwm_p = '0;
    pwm_n = '0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int m;
    void'($urandom(32'd4242));
    ticks(3);
    chk("R1 fault_n in reset", fault_n, 1);
    chk("R1 out_hiz in reset", out_hiz, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 startup_done after reset", startup_done, 0);
    chk("R1 cfg_q after reset", cfg_q, 0);

    // R2 start-up length, R3 strap capture
    cfg_strap = 3'b101;
    sd_n = 1'b1;
    ticks(S - 1);
    chk("R2 not done one edge early", startup_done, 0);
    chk("R4 hiz during start-up", out_hiz, 1);
    @(negedge clk);
    chk("R2 done after STARTUP_CYC edges", startup_done, 1);
    chk("R3 strap captured", cfg_q, 3'b101);
    chk("R4 enabled", out_hiz, 0);
    cfg_strap = 3'b010;
    ticks(3);
    chk("R3 strap held", cfg_q, 3'b101);

    mute = 1'b1; #1;
    chk("R4 mute floats", out_hiz, 1);
    chk("R4 mute no fault", fault_n, 1);
    @(negedge clk);
    mute = 1'b0; #1;
    chk("R4 unmute", out_hiz, 0);

    // R5 latched overcurrent
    oc_flag = 1'b1;
    @(negedge clk);
    oc_flag = 1'b0;
    chk("R5 oc latched", fault_n, 0);
    chk("R4 latched hiz", out_hiz, 1);
    ticks(5);
    chk("R5 oc held", fault_n, 0);
    chk("R4 latched hiz held", out_hiz, 1);
    // R6 clear and same-edge priority
    sd_n = 1'b0;
    @(negedge clk);
    chk("R6 shutdown clears", fault_n, 1);
    ot_flag = 1'b1;
    @(negedge clk);
    ot_flag = 1'b0;
    chk("R6 shutdown wins over ot", fault_n, 1);
    sd_n = 1'b1;
    ticks(S);
    chk("R2 restart after shutdown", startup_done, 1);
    chk("R3 new strap captured", cfg_q, 3'b010);
    chk("R6 still clear", fault_n, 1);

    // R7 undervoltage
    uv_flag = 1'b1;
    @(negedge clk);
    chk("R7 uv no fault", fault_n, 1);
    chk("R7 uv hiz", out_hiz, 1);
    chk("R2 uv drops done", startup_done, 0);
    ticks(3);
    uv_flag = 1'b0;
    ticks(S - 1);
    chk("R2 uv restart not yet", startup_done, 0);
    @(negedge clk);
    chk("R2 uv restart done", startup_done, 1);
    chk("R7 uv self-clears", out_hiz, 0);
    ov_flag = 1'b1;
    @(negedge clk);
    ov_flag = 1'b0;
    chk("R7 ov no fault", fault_n, 1);
    chk("R2 ov drops done", startup_done, 0);
    ticks(S);
    chk("R7 ov self-clears", out_hiz, 0);

    // R9 positive DC on channel 0, full duty
    sd_pulse();
    for (int k = 0; k < DCP; k++) run_period(0, 1'b0, L);
    chk("R9 no trip at DC_PERIODS", fault_n, 1);
    run_period(0, 1'b0, L);
    chk("R9 not before latch edge", fault_n, 1);
    @(negedge clk);
    chk("R9 pos trip ch0", fault_n, 0);
    sd_pulse();
    chk("R11 dc latch cleared", fault_n, 1);

    // R8 R9 negative 70% on channel 1
    for (int k = 0; k < DCP + 1; k++) run_period(1, 1'b1, 7);
    @(negedge clk);
    chk("R8 neg 70pct trip ch1", fault_n, 0);
    sd_pulse();

    // R10 polarity flip
    for (int k = 0; k < DCP; k++) run_period(0, 1'b0, L);
    for (int k = 0; k < DCP; k++) run_period(0, 1'b1, L);
    for (int k = 0; k < DCP; k++) run_period(0, 1'b0, L);
    @(negedge clk);
    chk("R10 flip restarts count", fault_n, 1);

    // R8 R10 exact 60% breaks the run
    sd_pulse();
    for (int k = 0; k < DCP; k++) run_period(0, 1'b0, L);
    run_period(0, 1'b0, 6);
    for (int k = 0; k < DCP; k++) run_period(0, 1'b0, L);
    @(negedge clk);
    chk("R8 60pct not imbalanced", fault_n, 1);
    run_period(0, 1'b0, L);
    @(negedge clk);
    chk("R10 count resumes after reset", fault_n, 0);

    // R11 partial measurement discarded by shutdown
    sd_pulse();
    for (int k = 0; k < DCP; k++) run_period(1, 1'b0, L);
    sd_pulse();
    for (int k = 0; k < DCP; k++) run_period(1, 1'b0, L);
    @(negedge clk);
    chk("R11 shutdown discards run", fault_n, 1);

    // random mute / supply glitches: R4 R7 R2
    ticks(S);
    m = S;
    for (int i = 0; i < 400; i++) begin
      mute    = ($urandom % 4) == 0;
      uv_flag = ($urandom % 24) == 0;
      ov_flag = ($urandom % 24) == 0;
      if (uv_flag || ov_flag) m = 0;
      else if (m < S) m++;
      @(negedge clk);
      chk("R2 random done", startup_done, (m == S));
      chk("R4 random hiz", out_hiz, exp_hiz(1'b1, mute, 1'b0, uv_flag, ov_flag, m == S));
      chk("R7 random fault", fault_n, 1);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule